// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one read or write burst request into the sequence of column addresses that the memory array walks through, one address per data beat. A request carries a starting column, a burst length of 2, 4 or 8 beats and an ordering mode. The ordering is either a count that wraps inside the burst-aligned block or an order built by XOR of the start offset with the beat index. Only the low column bits inside the burst-aligned block change. All higher bits are held at the starting value for every beat.

A one-cycle start strobe latches the request. From the next cycle on, the block drives one address per cycle together with a valid flag. A last flag marks the final beat. A new strobe during a burst abandons the old burst and starts the new one. A strobe that carries an unused length code starts nothing and raises an error pulse.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, valid_o, last_o and blen_err_o are low.
- R2: In the cycle after a start_i with a legal length code, valid_o is high and col_o equals col_i exactly. This is beat 0 of the burst.
- R3: With ilv_i = 0 (sequential), beat i carries the low offset bits equal to (start offset + i) modulo the burst length.
- R4: With ilv_i = 1 (interleave), beat i carries the low offset bits equal to the start offset XOR i.
- R5: The start offset is col_i bit 0 for length 2, bits 1..0 for length 4 and bits 2..0 for length 8. Every bit of col_i above that field appears unchanged on col_o on every beat.
- R6: blen_i = 1, 2 or 3 gives 2, 4 or 8 beats. valid_o stays high for exactly that many consecutive cycles and then falls, unless a new start arrives.
- R7: last_o is high on the final beat of a burst and low on every other cycle.
- R8: A start_i with a legal code during an active burst restarts the burst. In the next cycle col_o shows beat 0 of the new request.
- R9: blen_i = 0 with start_i raises blen_err_o for exactly the next cycle and starts no burst. An active burst continues with its own order.
- R10: With a start offset of zero, both modes give the same order 0,1,2,...

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a burst |
| col_i | input | COL_W | Starting column address |
| blen_i | input | 2 | Length code: 1=2, 2=4, 3=8 beats, 0 illegal |
| ilv_i | input | 1 | 0 sequential order, 1 interleave order |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Beat is valid |
| last_o | output | 1 | Final beat of the burst |
| blen_err_o | output | 1 | Illegal length code was strobed |

## Verification
Every legal length code is swept with both ordering modes. Each sweep uses all sixteen values of the four low column bits and two patterns in the upper bits. Non-zero offsets separate wrapping from XOR order. A zero offset confirms that both orders agree. Bit 3, and bit 2 for the shorter lengths, shows whether the field boundary is placed by the length code. Directed bursts cover a restart in the middle of a burst and an illegal code strobed both when idle and during a burst. These show that a rejected strobe leaves the running order untouched.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int OFS_W = 3;
  typedef enum logic [1:0] {BL_BAD = 2'd0, BL_2 = 2'd1, BL_4 = 2'd2, BL_8 = 2'd3} blen_e;
  typedef enum logic {ORD_SEQ = 1'b0, ORD_ILV = 1'b1} order_e;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       blen_i,
  output logic             load_o,
  output logic [1:0]       code_o,
  output logic [OFS_W-1:0] beat_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             err_o
);
  logic             active_q, err_q;
  logic [OFS_W-1:0] beat_q;
  logic [1:0]       code_q;
  logic [OFS_W:0]   len;
  logic [OFS_W-1:0] lim;
  logic             legal;

  assign legal  = (blen_i != BL_BAD);
  assign load_o = start_i && legal;
  assign len    = (OFS_W+1)'(1) << code_q;
  assign lim    = OFS_W'(len - (OFS_W+1)'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      code_q   <= BL_2;
      err_q    <= 1'b0;
    end else begin
      err_q <= start_i && !legal;
      if (load_o) begin
        active_q <= 1'b1;
        beat_q   <= '0;
        code_q   <= blen_i;
      end else if (active_q) begin
        if (beat_q == lim) active_q <= 1'b0;
        else beat_q <= beat_q + OFS_W'(1);
      end
    end
  end

  assign code_o  = code_q;
  assign beat_o  = beat_q;
  assign valid_o = active_q;
  assign last_o  = active_q && (beat_q == lim);
  assign err_o   = err_q;
endmodule

// File: rtl/burst_order.sv
module burst_order
  import burst_pkg::*;
(
  input  logic [OFS_W-1:0] base_i,
  input  logic [OFS_W-1:0] beat_i,
  input  logic [1:0]       code_i,
  input  logic             ilv_i,
  output logic [OFS_W-1:0] low_o
);
  logic [OFS_W:0]   len;
  logic [OFS_W-1:0] mask, ofs, ord;

  always_comb begin
    len  = (OFS_W+1)'(1) << code_i;
    mask = OFS_W'(len - (OFS_W+1)'(1));
    ofs  = base_i & mask;
    ord  = (ilv_i == ORD_ILV) ? (ofs ^ beat_i) : (ofs + beat_i);
    // bits outside the burst field keep the start value
    low_o = (base_i & ~mask) | (ord & mask);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [1:0]       blen_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             blen_err_o
);
  logic [COL_W-1:0] col_q;
  logic             ilv_q, load;
  logic [1:0]       code;
  logic [OFS_W-1:0] beat, low;

  burst_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i, .blen_i,
    .load_o(load), .code_o(code), .beat_o(beat),
    .valid_o, .last_o, .err_o(blen_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      ilv_q <= 1'b0;
    end else if (load) begin
      col_q <= col_i;
      ilv_q <= ilv_i;
    end
  end

  burst_order u_order (
    .base_i(col_q[OFS_W-1:0]), .beat_i(beat), .code_i(code),
    .ilv_i(ilv_q), .low_o(low)
  );

  generate
    if (COL_W > OFS_W) begin : g_hi
      assign col_o = {col_q[COL_W-1:OFS_W], low};
    end else begin : g_lo
      assign col_o = low[COL_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] col_i,
  input logic [1:0]       blen_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             blen_err_o
);
  p_start_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && blen_i != 2'd0) |=> (valid_o && col_o == $past(col_i)));

  p_hi_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o) && !$past(start_i)) |-> ((col_o >> 3) == $past(col_o >> 3)));

  p_drop_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !valid_o);

  p_last_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  p_err_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && blen_i == 2'd0) |=> blen_err_o);

  p_err_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_i && blen_i == 2'd0) |=> !blen_err_o);
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .col_i, .blen_i, .col_o, .valid_o, .last_o, .blen_err_o
);

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;
  localparam int COL_W = 10;
  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, ilv_i = 1'b0;
  logic [COL_W-1:0] col_i = '0;
  logic [1:0] blen_i = 2'd1;
  logic [COL_W-1:0] col_o;
  logic valid_o, last_o, blen_err_o;
  int n_run = 0, n_fail = 0;

  always #4 clk_i = ~clk_i;

  burst_col_gen #(.COL_W(COL_W)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_col(int col, int code, bit ilv, int i);
    int len = 1 << code;
    int msk = len - 1;
    int ofs = col & msk;
    int ord = ilv ? (ofs ^ i) : ((ofs + i) % len);
    return (col & ~msk) | ord;
  endfunction

  task automatic launch(int col, int code, bit ilv);
    @(negedge clk_i);
    start_i = 1'b1; col_i = COL_W'(col); blen_i = 2'(code); ilv_i = ilv;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // checks beats from current negedge; R3 R4 R5 R6 R7
  task automatic run_burst(int col, int code, bit ilv, int from);
    int len = 1 << code;
    for (int i = from; i < len; i++) begin
      int e = exp_col(col, code, ilv, i);
      chk(valid_o === 1'b1, "R6 valid", int'(valid_o), 1);
      chk(col_o === COL_W'(e), ilv ? "R4/R5 interleave" : "R3/R5 sequential", int'(col_o), e);
      chk(last_o === (i == len-1), "R7 last", int'(last_o), int'(i == len-1));
      if (i < len-1) @(negedge clk_i);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    chk(valid_o === 0 && last_o === 0 && blen_err_o === 0, "R1 reset", int'({valid_o,last_o,blen_err_o}), 0);
    rst_ni = 1'b1;
    for (int code = 1; code <= 3; code++)
      for (int m = 0; m < 2; m++)
        for (int hi = 0; hi < 2; hi++)
          for (int lo = 0; lo < 16; lo++) begin
            int col = (hi ? 10'h2A0 : 10'h140) | lo;
            launch(col, code, m[0]);
            chk(col_o === COL_W'(col), "R2 beat0", int'(col_o), col);
            if ((lo & 7) == 0)
              chk(col_o[2:0] === 3'(0), "R10 zero offset", int'(col_o[2:0]), 0);
            run_burst(col, code, m[0], 0);
            @(negedge clk_i);
            chk(valid_o === 1'b0, "R6 end", int'(valid_o), 0);
          end
    // R8 restart mid-burst
    launch(10'h0D5, 3, 1'b0);
    @(negedge clk_i); @(negedge clk_i);
    start_i = 1'b1; col_i = 10'h2A6; blen_i = 2'd2; ilv_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(col_o === 10'h2A6, "R8 restart", int'(col_o), 'h2A6);
    run_burst('h2A6, 2, 1'b1, 0);
    @(negedge clk_i);
    chk(valid_o === 1'b0, "R8 end", int'(valid_o), 0);
    // R9 illegal while idle
    @(negedge clk_i);
    start_i = 1'b1; col_i = 10'h3FF; blen_i = 2'd0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(blen_err_o === 1'b1, "R9 err idle", int'(blen_err_o), 1);
    chk(valid_o === 1'b0, "R9 no burst", int'(valid_o), 0);
    @(negedge clk_i);
    chk(blen_err_o === 1'b0, "R9 err one cycle", int'(blen_err_o), 0);
    // R9 illegal during burst
    launch(10'h133, 3, 1'b1);
    @(negedge clk_i);
    start_i = 1'b1; col_i = 10'h000; blen_i = 2'd0; ilv_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(blen_err_o === 1'b1, "R9 err active", int'(blen_err_o), 1);
    run_burst('h133, 3, 1'b1, 2);
    @(negedge clk_i);
    chk(valid_o === 1'b0, "R9 end", int'(valid_o), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule